// File: doc/BRIEF.md
# Decimating FIR Filter with Flush and Soft Reset

This block is an eight-tap decimating FIR filter. A control unit accepts tagged input words, runs a serial multiply-accumulate over the delay line, and places each decimated result in a one-word output buffer. The output buffer's valid flag is the block's service request. An input word can carry a sample, a flush marker, or both. A flush zeroes the delay line before any sample in the same word is shifted in. In cascade mode the flush is also passed to the next stage, attached to the next output word.

Software reaches the block through a small register port. The port holds a configuration word, a read-only status word and one register per coefficient. Writing the self-clearing reset bit aborts any work in progress. It also empties both buffers and clears the delay line, the decimation counter and the status. The configuration and the coefficients keep their values, so a block that was frozen stays frozen.

Top module: `decim_fir_ctl`

## Requirements
- R1: Each result equals sum over k of tap[k]*coef[k] (tap 0 is the newest sample, all values signed), arithmetically shifted right by 15 and saturated to the signed 16-bit range. The delay line holds zeros after reset.
- R2: Control register (address 0) bits [7:4] hold D-1. A result is produced only on every D-th accepted sample, where D runs from 1 to 16.
- R3: A word with both inSample and inFlush set zeroes every tap first, then shifts its sample into the cleared line.
- R4: With the mode field (control bits [1:0]) at 0, the filter is disabled. Words are drained without effect, so a flush leaves the taps and the counter unchanged.
- R5: In cascade mode (mode field 2), outFlush is set on the first result that follows a flush. In any other mode outFlush is 0.
- R6: Writing 1 to control bit 8 requests a soft reset. The bit always reads back as 0.
- R7: A soft reset zeroes the taps and the decimation counter. The status register (address 1) then reads 0.
- R8: The coefficients (addresses 8..15) and the control bits [7:0] keep their values across a soft reset.
- R9: A soft reset during a MAC sequence cancels that result. It also discards a word waiting in the input buffer and an unread output word, and outValid falls.
- R10: A soft reset takes priority over all other activity. Status bit 0 (busy) reads 1 in the cycle after the reset write.
- R11: While control bit 3 (freeze) is set, no buffered word is processed. A soft reset in freeze still clears the state, and the freeze bit stays set afterwards.
- R12: Control bit 2 (input disable) drops inReady. Busy stays 1 while a word is buffered or a MAC sequence runs, and then falls.
- R13: outValid (status bit 1) holds a result until outRead pops it. The result appears 11 clock edges after the accepting edge, or 12 if the word also flushed. Processing stalls while the buffer is full. Status bit 2 shows that an input word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| inValid | input | 1 | Input word offered |
| inReady | output | 1 | Input buffer can take a word |
| inData | input | 16 | Signed sample |
| inSample | input | 1 | Word carries a sample |
| inFlush | input | 1 | Word carries a flush marker |
| outValid | output | 1 | Result waiting (service request) |
| outData | output | 16 | Saturated signed result |
| outFlush | output | 1 | Flush marker forwarded to the next stage |
| outRead | input | 1 | Pops the output buffer |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data (combinational) |

## Verification
When the block is idle, a result is due 11 clock edges after the edge that accepts a sample, and 12 when the same word flushes. The bench counts falling edges from acceptance and checks that count exactly. Samples that must not produce a result are watched for 14 cycles, which is longer than any result path. Busy is read in the cycle right after a reset write, and the cleared status one cycle later. The buffer and freeze checks wait 15 to 20 cycles, long enough for any pending work to settle before the status is read.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FLUSH, ST_SHIFT, ST_MAC, ST_OUT, ST_RESET
  } ctlState_t;

  typedef struct packed {
    logic clearAll;   // soft reset: taps, accumulator, output buffer
    logic clearTaps;  // flush: delay line only
    logic shiftIn;    // push buffered sample into tap 0
    logic accClear;   // start of a MAC sequence
    logic macStep;    // accumulate one tap
    logic loadOut;    // move saturated result into output buffer
    logic tagFlush;   // forwarded flush marker for the loaded word
  } dpStrobe_t;

  localparam logic [1:0] MODE_OFF     = 2'd0;
  localparam logic [1:0] MODE_CASCADE = 2'd2;
endpackage

// File: rtl/fir_datapath.sv
module fir_datapath import fir_pkg::*; #(
  parameter int N_TAPS    = 8,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 36,
  parameter int FRAC_BITS = 15,
  parameter int IDX_W     = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpStrobe_t                  strobe,
  input  logic [IDX_W-1:0]           macIdx,
  input  logic [DATA_W-1:0]          sampleIn,
  input  logic [N_TAPS*COEF_W-1:0]   coefFlat,
  input  logic                       outRead,
  output logic                       outValid,
  output logic [DATA_W-1:0]          outData,
  output logic                       outFlush
);
  localparam int PROD_W = DATA_W + COEF_W;

  logic signed [DATA_W-1:0] taps [N_TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [COEF_W-1:0] coefSel;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  scaled;
  logic [DATA_W-1:0]        satVal;
  logic                     fits;
  logic                     tapsZero;

  assign coefSel = coefFlat[macIdx*COEF_W +: COEF_W];
  assign prod    = taps[macIdx] * coefSel;
  assign scaled  = acc >>> FRAC_BITS;
  assign fits    = scaled[ACC_W-1:DATA_W-1] == {(ACC_W-DATA_W+1){scaled[DATA_W-1]}};

  always_comb begin
    if (fits)                satVal = scaled[DATA_W-1:0];
    else if (scaled[ACC_W-1]) satVal = {1'b1, {(DATA_W-1){1'b0}}};
    else                     satVal = {1'b0, {(DATA_W-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll || strobe.clearTaps) begin
      for (int k = 0; k < N_TAPS; k++) taps[k] <= '0;
    end else if (strobe.shiftIn) begin
      taps[0] <= sampleIn;
      for (int k = 1; k < N_TAPS; k++) taps[k] <= taps[k-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll || strobe.accClear) acc <= '0;
    else if (strobe.macStep) acc <= acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clearAll) begin
      outValid <= 1'b0;
      outData  <= '0;
      outFlush <= 1'b0;
    end else if (strobe.loadOut) begin
      outValid <= 1'b1;
      outData  <= satVal;
      outFlush <= strobe.tagFlush;
    end else if (outRead) begin
      outValid <= 1'b0;
    end
  end

  always_comb begin
    tapsZero = 1'b1;
    for (int k = 0; k < N_TAPS; k++) if (taps[k] != '0) tapsZero = 1'b0;
  end

  assert_out_hold_R13: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outRead && !strobe.clearAll) |=> (outValid && $stable(outData)))
    else $error("result changed before it was read");
  assert_no_overwrite_R13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadOut |-> !outValid)
    else $error("output buffer overwritten");
  assert_flush_zeroes_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearTaps |=> tapsZero)
    else $error("flush left a nonzero tap");
  assert_reset_zeroes_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (tapsZero && !outValid))
    else $error("soft reset left state behind");
endmodule

// File: rtl/fir_control.sv
module fir_control import fir_pkg::*; #(
  parameter int N_TAPS = 8,
  parameter int DATA_W = 16,
  parameter int DEC_W  = 4,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inSample,
  input  logic              inFlush,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  input  logic [1:0]        cfgMode,
  input  logic              cfgInDis,
  input  logic              cfgFreeze,
  input  logic [DEC_W-1:0]  cfgDecim,
  input  logic              softReset,
  input  logic              outFull,
  output dpStrobe_t         strobe,
  output logic [IDX_W-1:0]  macIdx,
  output logic [DATA_W-1:0] sampleOut,
  output logic              busy,
  output logic              inPending
);
  ctlState_t         state;
  logic              bufValid, bufSample, bufFlush, pendFlush;
  logic [DATA_W-1:0] bufData;
  logic [DEC_W-1:0]  decCount;
  logic [IDX_W-1:0]  idx;

  assign inReady   = !bufValid && !cfgInDis && (state != ST_RESET);
  assign busy      = bufValid || (state != ST_IDLE);
  assign inPending = bufValid;
  assign macIdx    = idx;
  assign sampleOut = bufData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; bufValid <= 1'b0; bufSample <= 1'b0; bufFlush <= 1'b0;
      bufData <= '0; decCount <= '0; idx <= '0; pendFlush <= 1'b0;
    end else begin
      if (softReset) begin
        state <= ST_RESET;
      end else begin
        case (state)
          ST_RESET: begin
            bufValid <= 1'b0; decCount <= '0; idx <= '0; pendFlush <= 1'b0;
            state <= ST_IDLE;
          end
          ST_IDLE: if (bufValid && !cfgFreeze) begin
            if (cfgMode == MODE_OFF) bufValid <= 1'b0;
            else if (bufFlush)       state <= ST_FLUSH;
            else if (bufSample)      state <= ST_SHIFT;
            else                     bufValid <= 1'b0;
          end
          ST_FLUSH: begin
            if (cfgMode == MODE_CASCADE) pendFlush <= 1'b1;
            if (bufSample) state <= ST_SHIFT;
            else begin bufValid <= 1'b0; state <= ST_IDLE; end
          end
          ST_SHIFT: begin
            bufValid <= 1'b0;
            if (decCount >= cfgDecim) begin
              decCount <= '0; idx <= '0; state <= ST_MAC;
            end else begin
              decCount <= decCount + 1'b1; state <= ST_IDLE;
            end
          end
          ST_MAC: begin
            idx <= idx + 1'b1;
            if (idx == IDX_W'(N_TAPS-1)) state <= ST_OUT;
          end
          ST_OUT: if (!outFull) begin
            pendFlush <= 1'b0; state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
      if (inValid && inReady) begin
        bufValid <= 1'b1; bufSample <= inSample; bufFlush <= inFlush; bufData <= inData;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.clearAll  = (state == ST_RESET);
    strobe.clearTaps = (state == ST_FLUSH);
    strobe.shiftIn   = (state == ST_SHIFT);
    strobe.accClear  = (state == ST_SHIFT);
    strobe.macStep   = (state == ST_MAC);
    strobe.loadOut   = (state == ST_OUT) && !outFull;
    strobe.tagFlush  = pendFlush;
    if (softReset) begin
      strobe.clearTaps = 1'b0; strobe.shiftIn = 1'b0; strobe.accClear = 1'b0;
      strobe.macStep = 1'b0; strobe.loadOut = 1'b0;
    end
  end

  assert_reset_first_R10: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (state == ST_RESET))
    else $error("soft reset did not take priority");
  assert_reset_drops_buf_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESET && !softReset) |=> (state == ST_IDLE && !bufValid && decCount == '0))
    else $error("soft reset kept buffered work");
  assert_frozen_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cfgFreeze && !softReset) |=> (state == ST_IDLE))
    else $error("work started while frozen");
endmodule

// File: rtl/decim_fir_ctl.sv
module decim_fir_ctl import fir_pkg::*; #(
  parameter int N_TAPS    = 8,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int ACC_W     = 36,
  parameter int FRAC_BITS = 15,
  parameter int DEC_W     = 4,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inSample,
  input  logic              inFlush,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outFlush,
  input  logic              outRead,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [COEF_W-1:0] regWdata,
  output logic [COEF_W-1:0] regRdata
);
  localparam int IDX_W     = $clog2(N_TAPS);
  localparam int SRES_BIT  = 4 + DEC_W;
  localparam int COEF_BASE = (1 << ADDR_W) - N_TAPS;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = '0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(1);

  logic [SRES_BIT-1:0]        cfgReg;
  logic [COEF_W-1:0]          coefReg [N_TAPS];
  logic [N_TAPS*COEF_W-1:0]   coefFlat;
  logic                       softReset, busy, inPending;
  dpStrobe_t                  strobe;
  logic [IDX_W-1:0]           macIdx;
  logic [DATA_W-1:0]          sampleBus;

  assign softReset = regWe && (regAddr == ADDR_CTRL) && regWdata[SRES_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) cfgReg <= '0;
    else if (regWe && regAddr == ADDR_CTRL) cfgReg <= regWdata[SRES_BIT-1:0];
  end

  for (genvar g = 0; g < N_TAPS; g++) begin : gCoef
    always_ff @(posedge clk) begin
      if (!rstN) coefReg[g] <= '0;
      else if (regWe && regAddr == ADDR_W'(COEF_BASE + g)) coefReg[g] <= regWdata;
    end
    assign coefFlat[g*COEF_W +: COEF_W] = coefReg[g];
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_CTRL) regRdata = {{(COEF_W-SRES_BIT){1'b0}}, cfgReg};
    else if (regAddr == ADDR_STAT) regRdata = {{(COEF_W-3){1'b0}}, inPending, outValid, busy};
    for (int g = 0; g < N_TAPS; g++)
      if (regAddr == ADDR_W'(COEF_BASE + g)) regRdata = coefReg[g];
  end

  fir_control #(.N_TAPS(N_TAPS), .DATA_W(DATA_W), .DEC_W(DEC_W), .IDX_W(IDX_W)) uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample), .inFlush(inFlush),
    .inData(inData), .inReady(inReady), .cfgMode(cfgReg[1:0]), .cfgInDis(cfgReg[2]),
    .cfgFreeze(cfgReg[3]), .cfgDecim(cfgReg[4 +: DEC_W]), .softReset(softReset),
    .outFull(outValid), .strobe(strobe), .macIdx(macIdx), .sampleOut(sampleBus),
    .busy(busy), .inPending(inPending));

  fir_datapath #(.N_TAPS(N_TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W),
                 .FRAC_BITS(FRAC_BITS), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .macIdx(macIdx), .sampleIn(sampleBus),
    .coefFlat(coefFlat), .outRead(outRead), .outValid(outValid), .outData(outData),
    .outFlush(outFlush));
endmodule

// File: tb/decim_fir_ctl_test.sv
module decim_fir_ctl_test;
  localparam int NT = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSample = 1'b0, inFlush = 1'b0, inReady;
  logic [15:0] inData = '0;
  logic outValid, outFlush, outRead = 1'b0;
  logic [15:0] outData;
  logic regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [15:0] regWdata = '0, regRdata;

  int total = 0, bad = 0;
  int mTap[NT];
  int mCoef[NT];
  int baseCoef[NT];
  int mCount = 0, mPend = 0, mMode = 0, mDec = 0;
  int expOut = 0, expData = 0, expFlag = 0;
  int cfgVal = 0;
  int unsigned seed = 32'h1357_2468;

  always #10 clk = ~clk;

  decim_fir_ctl uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSample(inSample), .inFlush(inFlush), .outValid(outValid), .outData(outData),
    .outFlush(outFlush), .outRead(outRead), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata));

  task automatic check(input string req, input int act, input int exp, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input int a, input int d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'(a); regWdata = 16'(d);
    @(posedge clk);
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input int a, output int v);
    regAddr = 4'(a);
    #1;
    v = int'(regRdata);
  endtask

  task automatic setCfg(input int mode, input int dis, input int frz, input int dec);
    cfgVal = mode | (dis << 2) | (frz << 3) | (dec << 4);
    mMode = mode; mDec = dec;
    writeReg(0, cfgVal);
  endtask

  task automatic softRst();
    writeReg(0, cfgVal | 256);
    for (int k = 0; k < NT; k++) mTap[k] = 0;
    mCount = 0; mPend = 0;
  endtask

  function automatic int modelOut();
    longint acc = 0;
    for (int k = 0; k < NT; k++) acc += longint'(mTap[k]) * longint'(mCoef[k]);
    acc = acc >>> 15;
    if (acc > 32767) return 32767;
    if (acc < -32768) return -32768;
    return int'(acc);
  endfunction

  task automatic modelWord(input int d, input int s, input int f);
    expOut = 0;
    if (mMode == 0) return;
    if (f != 0) begin
      for (int k = 0; k < NT; k++) mTap[k] = 0;
      if (mMode == 2) mPend = 1;
    end
    if (s != 0) begin
      for (int k = NT - 1; k > 0; k--) mTap[k] = mTap[k-1];
      mTap[0] = d;
      if (mCount >= mDec) begin
        mCount = 0; expOut = 1; expData = modelOut(); expFlag = mPend; mPend = 0;
      end else mCount++;
    end
  endtask

  task automatic sendWord(input int d, input int s, input int f);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inData = 16'(d); inSample = (s != 0); inFlush = (f != 0); inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0; inSample = 1'b0; inFlush = 1'b0;
  endtask

  task automatic expectResult(input string req, input int lat);
    int n = 0;
    if (expOut != 0) begin
      while (!outValid && n < 40) begin @(negedge clk); n++; end
      check(req, int'(outValid), 1, "result present");
      if (lat >= 0) check("R13", n, lat, "cycles from accept to result");
      check(req, int'($signed(outData)), expData, "result value");
      check("R5", int'(outFlush), expFlag, "forwarded flush marker");
      outRead = 1'b1;
      @(posedge clk);
      @(negedge clk);
      outRead = 1'b0;
    end else begin
      repeat (14) @(negedge clk);
      check(req, int'(outValid), 0, "no result expected");
    end
  endtask

  task automatic procWord(input int d, input int s, input int f, input string req, input int lat);
    modelWord(d, s, f);
    sendWord(d, s, f);
    expectResult(req, lat);
  endtask

  function automatic int nextSample();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(16'(seed >> 9)));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    baseCoef = '{1200, -2500, 4000, -800, 3000, 700, -1500, 2200};
    for (int k = 0; k < NT; k++) begin mTap[k] = 0; mCoef[k] = baseCoef[k]; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    check("R12", int'(inReady), 1, "inReady after reset");
    check("R13", int'(outValid), 0, "outValid after reset");
    readReg(1, v); check("R7", v, 0, "status after reset");
    readReg(0, v); check("R6", v, 0, "control after reset");

    for (int k = 0; k < NT; k++) writeReg(8 + k, mCoef[k]);

    // latency, plain and with flush
    setCfg(1, 0, 0, 0);
    procWord(1000, 1, 0, "R1", 11);
    procWord(-2000, 1, 1, "R3", 12);

    // sweep every decimation factor, flush mixed in
    for (int dec = 0; dec < 16; dec++) begin
      setCfg(1, 0, 0, dec);
      for (int i = 0; i < 2 * (dec + 1) + 1; i++) begin
        int f = ((i % 5) == 3) ? 1 : 0;
        procWord(nextSample(), 1, f, (f != 0) ? "R3" : "R2", -1);
      end
    end

    // saturation on both rails
    for (int k = 0; k < NT; k++) begin mCoef[k] = 32767; writeReg(8 + k, 32767); end
    setCfg(1, 0, 0, 0);
    for (int i = 0; i < NT; i++) procWord(32767, 1, 0, "R1", -1);
    for (int i = 0; i < NT; i++) procWord(-32768, 1, 0, "R1", -1);
    for (int k = 0; k < NT; k++) begin mCoef[k] = baseCoef[k]; writeReg(8 + k, mCoef[k]); end

    // disabled filter ignores flush
    for (int i = 0; i < 3; i++) procWord(nextSample(), 1, 0, "R1", -1);
    setCfg(0, 0, 0, 0);
    procWord(1234, 1, 1, "R4", -1);
    setCfg(1, 0, 0, 0);
    procWord(2222, 1, 0, "R4", -1);

    // cascade forwarding
    setCfg(2, 0, 0, 2);
    softRst();
    procWord(3000, 1, 0, "R5", -1);
    procWord(-4000, 1, 1, "R5", -1);
    procWord(5000, 1, 0, "R5", -1);
    for (int i = 0; i < 3; i++) procWord(nextSample(), 1, 0, "R5", -1);
    procWord(0, 0, 1, "R5", -1);
    for (int i = 0; i < 3; i++) procWord(nextSample(), 1, 0, "R5", -1);
    setCfg(1, 0, 0, 0);
    procWord(700, 1, 1, "R5", -1);

    // soft reset clears counter and taps, keeps config and coefficients
    setCfg(1, 0, 0, 2);
    procWord(9000, 1, 0, "R2", -1);
    softRst();
    readReg(1, v); check("R10", v & 1, 1, "busy during soft reset");
    @(negedge clk);
    readReg(1, v); check("R7", v, 0, "status after soft reset");
    readReg(0, v); check("R6", v, cfgVal, "control readback, reset bit clear");
    check("R8", v & 255, cfgVal & 255, "config kept");
    for (int k = 0; k < NT; k++) begin
      readReg(8 + k, v); check("R8", v, mCoef[k] & 32'hFFFF, "coefficient kept");
    end
    procWord(1500, 1, 0, "R7", -1);
    procWord(-2500, 1, 0, "R7", -1);
    procWord(3500, 1, 0, "R7", -1);

    // soft reset aborts a running MAC sequence
    setCfg(1, 0, 0, 0);
    sendWord(8000, 1, 0);
    repeat (4) @(negedge clk);
    softRst();
    repeat (20) @(negedge clk);
    check("R9", int'(outValid), 0, "aborted result absent");

    // soft reset drops buffered input and unread output
    sendWord(1111, 1, 0);
    while (!outValid) @(negedge clk);
    sendWord(2222, 1, 0);
    sendWord(3333, 1, 0);
    repeat (15) @(negedge clk);
    readReg(1, v); check("R13", v, 7, "stalled: busy, result and input pending");
    check("R13", int'(outValid), 1, "unread result held");
    softRst();
    @(negedge clk);
    readReg(1, v); check("R9", v, 0, "buffers discarded");
    check("R9", int'(outValid), 0, "outValid dropped");
    procWord(4321, 1, 0, "R7", -1);

    // freeze
    setCfg(1, 0, 1, 0);
    sendWord(555, 1, 0);
    repeat (20) @(negedge clk);
    check("R11", int'(outValid), 0, "no result while frozen");
    readReg(1, v); check("R11", v, 5, "word waits while frozen");
    softRst();
    @(negedge clk);
    readReg(0, v); check("R11", (v >> 3) & 1, 1, "freeze bit kept by soft reset");
    readReg(1, v); check("R9", v, 0, "frozen word discarded");
    sendWord(777, 1, 0);
    repeat (20) @(negedge clk);
    check("R11", int'(outValid), 0, "still frozen after soft reset");
    modelWord(777, 1, 0);
    setCfg(1, 0, 0, 0);
    expectResult("R11", -1);

    // input disable and busy
    setCfg(1, 1, 0, 0);
    check("R12", int'(inReady), 0, "inReady with input disabled");
    setCfg(1, 0, 0, 0);
    modelWord(900, 1, 0);
    sendWord(900, 1, 0);
    setCfg(1, 1, 0, 0);
    readReg(1, v); check("R12", v & 1, 1, "busy during MAC");
    check("R12", int'(inReady), 0, "inReady low while disabled");
    repeat (15) @(negedge clk);
    readReg(1, v); check("R12", v, 2, "busy falls, result waiting");
    expectResult("R12", -1);
    setCfg(1, 0, 0, 0);
    check("R12", int'(inReady), 1, "inReady back after enable");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule